// File: doc/BRIEF.md
# GPIO Port Interrupt Detector

This block watches the already-synchronized input pins of one GPIO port and turns selected pin activity into an interrupt request. Every pin has its own trigger setting: a rising edge, a falling edge, either edge, a high level or a low level. When a pin's condition is met, a sticky status bit is set. An enable mask selects which status bits may raise the port's interrupt line. The bank-level logic ORs that line with the lines of the other ports in the bank.

Software reaches the block through a small word-wide register port with four locations. These hold the trigger configuration, the interrupt enables, the read-only status and a write-one-to-clear location for status. Edge detection compares each pin with a copy of it registered one cycle earlier. A pin's status bit therefore reflects changes between consecutive clock samples.

Top module: `gpio_port_irq_det`

## Requirements
- R1: While reset is asserted, and right after it, the trigger configuration, the enable mask and the status bits all read as zero, and `irq_req` is low.
- R2: Register locations by `bus_addr`: 0 is the trigger configuration (24 bits, read/write, upper read bits zero); 1 is the enable mask (8 bits, read/write); 2 is status (read-only); 3 is the clear location (write-only, reads zero). A write to location 0 or 1 takes effect at the clock edge on which `bus_we` is high and is visible to reads afterwards.
- R3: For pin i, configuration bit 8+i set selects edge triggering. In edge mode, bit 16+i set means either edge sets status. With bit 16+i clear, bit i set means a rising edge and bit i clear means a falling edge.
- R4: With configuration bit 8+i clear, pin i is level-sensitive. Bit i set means status is set on every cycle the pin is high; bit i clear means on every cycle it is low.
- R5: An edge is a difference between the pin and its value one clock earlier. That delayed copy is zero out of reset. A pin held steady produces no edge event.
- R6: Status bits stay set until cleared. Writing a 1 to bit i at location 3 clears status bit i on that clock edge. A 0 bit in that write leaves status bit i unchanged.
- R7: When pin i's trigger condition holds in the same cycle as a clear of bit i, the status bit stays set.
- R8: A clear of a level-sensitive pin whose level is still active leaves its status bit set. A clear after the level has gone away drops it.
- R9: `irq_req` is high in exactly those cycles in which some status bit and its matching enable bit are both 1. It follows register changes in the same cycle, without any added delay.
- R10: A write to the status location (2) has no effect on status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 8 | Synchronized pin levels |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | 2 | Register location select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected location (combinational) |
| irq_req | output | 1 | Port interrupt request |

## Verification
A trigger event and a software clear can land on the same status bit in the same clock cycle. The bench provokes this in two ways. It raises a rising-edge pin on the very cycle a clear of that bit is written. It also clears a level-sensitive pin while its level is still active. In both cases the bench's behavioural model predicts that the bit survives, and the status read and `irq_req` are compared against the model on every clock.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   // register locations on the port's word bus
   typedef enum logic [1:0] {
      LOC_TRIG  = 2'd0,
      LOC_ENAB  = 2'd1,
      LOC_STAT  = 2'd2,
      LOC_CLEAR = 2'd3
   } reg_loc_e;

   // per-pin trigger setting gathered from the three configuration lanes
   typedef struct packed {
      logic dual;     // lane 2: either edge (edge mode only)
      logic is_edge;  // lane 1: edge mode when set, level mode when clear
      logic hi;       // lane 0: rising / high when set
   } trig_t;

endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
   import gpio_irq_pkg::*;
#(
   parameter int NPINS  = 8,
   parameter int LANE   = 8,
   parameter int DATA_W = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_we,
   input  logic [1:0]           bus_addr,
   input  logic [DATA_W-1:0]    bus_wdata,
   input  logic [NPINS-1:0]     status,
   output logic [DATA_W-1:0]    bus_rdata,
   output trig_t [NPINS-1:0]    trig_cfg,
   output logic [NPINS-1:0]     irq_en,
   output logic [NPINS-1:0]     clr_mask
);

   localparam int CFG_W = 3 * LANE;

   logic [CFG_W-1:0] cfg_q;
   logic [NPINS-1:0] en_q;
   reg_loc_e         loc;

   assign loc = reg_loc_e'(bus_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
         en_q  <= '0;
      end else if (bus_we) begin
         case (loc)
            LOC_TRIG: cfg_q <= bus_wdata[CFG_W-1:0];
            LOC_ENAB: en_q  <= bus_wdata[NPINS-1:0];
            default: ;
         endcase
      end
   end

   assign clr_mask = (bus_we && loc == LOC_CLEAR) ? bus_wdata[NPINS-1:0] : '0;
   assign irq_en   = en_q;

   // gather the three lanes of each pin into one trigger field
   for (genvar p = 0; p < NPINS; p++) begin : g_lane
      assign trig_cfg[p].dual    = cfg_q[2*LANE + p];
      assign trig_cfg[p].is_edge = cfg_q[LANE + p];
      assign trig_cfg[p].hi      = cfg_q[p];
   end

   if (DATA_W > CFG_W) begin : g_wide
      logic wdata_unused;
      assign wdata_unused = ^bus_wdata[DATA_W-1:CFG_W];
   end

   always_comb begin
      bus_rdata = '0;
      case (loc)
         LOC_TRIG: bus_rdata[CFG_W-1:0] = cfg_q;
         LOC_ENAB: bus_rdata[NPINS-1:0] = en_q;
         LOC_STAT: bus_rdata[NPINS-1:0] = status;
         default:  bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/gpio_irq_pin_det.sv
module gpio_irq_pin_det
   import gpio_irq_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  pin,
   input  trig_t trig,
   input  logic  clr,
   output logic  evt,
   output logic  prev,
   output logic  status
);

   logic prev_q;
   logic st_q;
   logic rise;
   logic fall;

   assign rise = pin & ~prev_q;
   assign fall = ~pin & prev_q;

   always_comb begin
      if (trig.is_edge) begin
         if (trig.dual) evt = rise | fall;
         else           evt = trig.hi ? rise : fall;
      end else begin
         evt = trig.hi ? pin : ~pin;
      end
   end

   // a detected condition takes priority over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         st_q   <= 1'b0;
      end else begin
         prev_q <= pin;
         st_q   <= evt | (st_q & ~clr);
      end
   end

   assign prev   = prev_q;
   assign status = st_q;

endmodule

// File: rtl/gpio_irq_combine.sv
module gpio_irq_combine #(
   parameter int NPINS   = 8,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] status,
   input  logic [NPINS-1:0] irq_en,
   output logic             irq
);

   logic [NPINS-1:0] pending;
   assign pending = status & irq_en;

   if (IRQ_REG) begin : g_flop
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= |pending;
      end
      assign irq = irq_q;
   end else begin : g_direct
      logic clk_unused;
      assign clk_unused = clk ^ rst_n;
      assign irq = |pending;
   end

endmodule

// File: rtl/gpio_port_irq_det.sv
module gpio_port_irq_det
   import gpio_irq_pkg::*;
#(
   parameter int NPINS   = 8,
   parameter int LANE    = 8,
   parameter int DATA_W  = 32,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NPINS-1:0]  pin_in,
   input  logic              bus_we,
   input  logic [1:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_req
);

   localparam int CFG_W = 3 * LANE;

   if (NPINS < 1 || NPINS > LANE) begin : g_bad_npins
      $error("NPINS must lie between 1 and LANE");
   end
   if (DATA_W < CFG_W) begin : g_bad_width
      $error("DATA_W must hold all three configuration lanes");
   end

   trig_t [NPINS-1:0] trig_w;
   logic  [NPINS-1:0] en_w;
   logic  [NPINS-1:0] clr_w;
   logic  [NPINS-1:0] evt_w;
   logic  [NPINS-1:0] prev_w;
   logic  [NPINS-1:0] stat_w;

   gpio_irq_regs #(
      .NPINS  (NPINS),
      .LANE   (LANE),
      .DATA_W (DATA_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .status    (stat_w),
      .bus_rdata (bus_rdata),
      .trig_cfg  (trig_w),
      .irq_en    (en_w),
      .clr_mask  (clr_w)
   );

   for (genvar p = 0; p < NPINS; p++) begin : g_pin
      gpio_irq_pin_det u_det (
         .clk    (clk),
         .rst_n  (rst_n),
         .pin    (pin_in[p]),
         .trig   (trig_w[p]),
         .clr    (clr_w[p]),
         .evt    (evt_w[p]),
         .prev   (prev_w[p]),
         .status (stat_w[p])
      );
   end

   gpio_irq_combine #(
      .NPINS   (NPINS),
      .IRQ_REG (IRQ_REG)
   ) u_comb (
      .clk    (clk),
      .rst_n  (rst_n),
      .status (stat_w),
      .irq_en (en_w),
      .irq    (irq_req)
   );

endmodule

// File: rtl/gpio_port_irq_det_chk.sv
module gpio_port_irq_det_chk
   import gpio_irq_pkg::*;
#(
   parameter int NPINS   = 8,
   parameter bit IRQ_REG = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NPINS-1:0]  pin_in,
   input trig_t [NPINS-1:0] trig,
   input logic [NPINS-1:0]  en_vec,
   input logic [NPINS-1:0]  clr_vec,
   input logic [NPINS-1:0]  evt_vec,
   input logic [NPINS-1:0]  prev_vec,
   input logic [NPINS-1:0]  stat_vec,
   input logic              irq_req
);

   logic [NPINS-1:0] edge_sel;
   for (genvar p = 0; p < NPINS; p++) begin : g_sel
      assign edge_sel[p] = trig[p].is_edge;
   end

   assert_reset_clears_R1: assert property (@(posedge clk)
      !rst_n |=> (en_vec == '0 && stat_vec == '0));

   assert_steady_pin_no_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_sel & evt_vec & ~(pin_in ^ prev_vec)) == '0);

   assert_clear_drops_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stat_vec & $past(clr_vec & ~evt_vec)) == '0));

   assert_no_spurious_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stat_vec & ~$past(stat_vec | evt_vec)) == '0));

   assert_event_beats_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stat_vec & $past(evt_vec)) == $past(evt_vec)));

   if (IRQ_REG) begin : g_irq_flop
      assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
         ((stat_vec & en_vec) == '0) |=> !irq_req);
      assert_irq_raised_R9: assert property (@(posedge clk) disable iff (!rst_n)
         ($countones(stat_vec & en_vec) > 0) |=> irq_req);
   end else begin : g_irq_direct
      assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (en_vec == '0) |-> !irq_req);
      assert_irq_raised_R9: assert property (@(posedge clk) disable iff (!rst_n)
         ($countones(stat_vec & en_vec) > 0) |-> irq_req);
   end

endmodule

bind gpio_port_irq_det gpio_port_irq_det_chk #(
   .NPINS   (NPINS),
   .IRQ_REG (IRQ_REG)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .pin_in   (pin_in),
   .trig     (trig_w),
   .en_vec   (en_w),
   .clr_vec  (clr_w),
   .evt_vec  (evt_w),
   .prev_vec (prev_w),
   .stat_vec (stat_w),
   .irq_req  (irq_req)
);

// File: tb/gpio_port_irq_det_bench.sv
module gpio_port_irq_det_bench;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  pin_in = '0;
   logic        bus_we = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   wire  [31:0] bus_rdata;
   wire         irq_req;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // behavioural reference state
   logic [23:0] m_cfg = '0;
   logic [7:0]  m_en = '0;
   logic [7:0]  m_st = '0;
   logic [7:0]  m_prev = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_port_irq_det u_gpio_port_irq_det (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_in    (pin_in),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_req   (irq_req)
   );

   // trigger condition of one pin per R3/R4/R5
   function automatic bit pin_fires(int i);
      bit now_v  = pin_in[i];
      bit was_v  = m_prev[i];
      bit edge_m = m_cfg[8+i];
      bit any_m  = m_cfg[16+i];
      bit up_m   = m_cfg[i];
      if (!edge_m) return up_m ? now_v : !now_v;
      if (any_m)   return now_v != was_v;
      if (up_m)    return now_v && !was_v;
      return !now_v && was_v;
   endfunction

   function automatic logic [31:0] model_read(logic [1:0] a);
      case (a)
         2'd0:    return {8'h00, m_cfg};
         2'd1:    return {24'h0, m_en};
         2'd2:    return {24'h0, m_st};
         default: return 32'h0;
      endcase
   endfunction

   always @(posedge clk) begin
      logic [7:0] nxt;
      logic [7:0] wipe;
      if (!rst_n) begin
         m_cfg  <= '0;
         m_en   <= '0;
         m_st   <= '0;
         m_prev <= '0;
      end else begin
         wipe = (bus_we && bus_addr == 2'd3) ? bus_wdata[7:0] : 8'h00;
         for (int i = 0; i < 8; i++)
            nxt[i] = pin_fires(i) || (m_st[i] && !wipe[i]);
         m_st   <= nxt;
         m_prev <= pin_in;
         if (bus_we && bus_addr == 2'd0) m_cfg <= bus_wdata[23:0];
         if (bus_we && bus_addr == 2'd1) m_en  <= bus_wdata[7:0];
      end
   end

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   // per-clock comparison against the model, sampled mid low phase
   initial begin
      forever begin
         @(negedge clk);
         #(CLK_PERIOD/4);
         if (rst_n && !done) begin
            check("R9 irq_req vs model", {31'h0, irq_req}, {31'h0, |(m_st & m_en)});
            check("R2 bus_rdata vs model", bus_rdata, model_read(bus_addr));
         end
      end
   end

   task automatic wr(logic [1:0] a, logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(string req, logic [1:0] a, logic [31:0] exp);
      @(negedge clk);
      bus_addr = a;
      #1;
      check(req, bus_rdata, exp);
   endtask

   task automatic pins(logic [7:0] v);
      @(negedge clk);
      pin_in = v;
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      // R1: values while reset is held
      repeat (2) @(negedge clk);
      bus_addr = 2'd0; #1; check("R1 trig cfg in reset", bus_rdata, 32'h0);
      bus_addr = 2'd1; #1; check("R1 enables in reset", bus_rdata, 32'h0);
      bus_addr = 2'd2; #1; check("R1 status in reset", bus_rdata, 32'h0);
      check("R1 irq in reset", {31'h0, irq_req}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      // all pins rising edge, then wipe the level-low hits left from reset
      wr(2'd0, 32'h0000_FFFF);
      wr(2'd3, 32'h0000_00FF);
      rd("R6 status after clear", 2'd2, 32'h0);
      rd("R6 clear location reads zero", 2'd3, 32'h0);
      rd("R2 trig cfg read back", 2'd0, 32'h0000_FFFF);

      // R3 rising edge on pin 2, enable gates irq (R9)
      pins(8'h04);
      rd("R3 rising edge sets bit 2", 2'd2, 32'h04);
      check("R9 irq low while disabled", {31'h0, irq_req}, 32'h0);
      wr(2'd1, 32'h04);
      #1; check("R9 irq high once enabled", {31'h0, irq_req}, 32'h1);

      // R6 zero bits do nothing, one bits clear
      wr(2'd3, 32'h00);
      rd("R6 zero clear keeps bit", 2'd2, 32'h04);
      wr(2'd3, 32'h04);
      rd("R6 one clears bit", 2'd2, 32'h00);
      #1; check("R9 irq drops with status", {31'h0, irq_req}, 32'h0);

      // R5 steady high pin gives no further edge
      repeat (3) @(negedge clk);
      rd("R5 steady pin no event", 2'd2, 32'h00);

      // R3 falling edge on pin 3
      wr(2'd0, 32'h0000_FFF7);
      pins(8'h0C);
      rd("R3 falling mode ignores rise", 2'd2, 32'h00);
      pins(8'h04);
      rd("R3 falling edge sets bit 3", 2'd2, 32'h08);
      wr(2'd3, 32'h08);

      // R3 either edge on pin 5
      wr(2'd0, 32'h0020_FFD7);
      pins(8'h24);
      rd("R3 dual mode rise", 2'd2, 32'h20);
      wr(2'd3, 32'h20);
      rd("R6 dual bit cleared", 2'd2, 32'h00);
      pins(8'h04);
      rd("R3 dual mode fall", 2'd2, 32'h20);
      wr(2'd3, 32'h20);

      // R4/R8 level high on pin 6
      wr(2'd0, 32'h0020_BFD7);
      rd("R4 level high idle", 2'd2, 32'h00);
      pins(8'h44);
      rd("R4 level high sets bit 6", 2'd2, 32'h40);
      wr(2'd3, 32'h40);
      rd("R8 clear during active level", 2'd2, 32'h40);
      pins(8'h04);
      wr(2'd3, 32'h40);
      rd("R8 clear after level gone", 2'd2, 32'h00);

      // R4 level low on pin 7
      wr(2'd0, 32'h0020_3F57);
      rd("R4 level low sets bit 7", 2'd2, 32'h80);
      pins(8'h84);
      wr(2'd3, 32'h80);
      rd("R4 level low released", 2'd2, 32'h00);

      // R7 edge and clear on pin 1 in one cycle
      pins(8'h86);
      rd("R3 rising on pin 1", 2'd2, 32'h02);
      pins(8'h84);
      @(negedge clk);
      pin_in = 8'h86;
      bus_we = 1'b1; bus_addr = 2'd3; bus_wdata = 32'h02;
      @(negedge clk);
      bus_we = 1'b0; bus_wdata = '0;
      rd("R7 edge wins over clear", 2'd2, 32'h02);

      // R10 write to status location ignored
      wr(2'd2, 32'h0);
      rd("R10 status write ignored", 2'd2, 32'h02);
      wr(2'd3, 32'h02);
      rd("R6 pin 1 cleared", 2'd2, 32'h00);

      // R2 width masking on read back
      wr(2'd0, 32'hAB12_3456);
      rd("R2 trig cfg masked to 24 bits", 2'd0, 32'h0012_3456);
      wr(2'd1, 32'hFFFF_FF5A);
      rd("R2 enables masked to 8 bits", 2'd1, 32'h0000_005A);
      repeat (4) @(negedge clk);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule